// File: doc/BRIEF.md
# Legacy-Mode IDE Function Configuration Registers

This block is the configuration register file of a two-channel disk controller function on a PCI-style bus. A single request port carries one read or one write per cycle. The request names a byte offset and a length of 1, 2 or 4 bytes. Lane 0 of the data word maps to the named offset, and the higher lanes map to the following offsets, so accesses are little-endian. Each stored byte has a fixed write mask. Bytes and bits whose mask is zero keep their value whatever is written to them. After reset every byte holds a fixed image: identity and class bytes, command and status words, interrupt line, capability pointer and the vendor timing registers.

Read data passes through a mode filter. The low nibble of the programming-interface byte selects the mode. While that nibble is 0xA (compatibility mode), bytes of the four channel base-address registers at 0x10..0x1F read as zero, one byte at a time. In the same mode, a full-word read of the DMA base register at 0x20 that still holds only the I/O-space flag returns a fixed fallback base. Two channel interrupt levels are registered onto output lines. Each level is also copied into bit 7 of a status byte, at 0x70 for channel 0 and 0x78 for channel 1.

Top module: `ide_cfg_space`

## Requirements
- R1: Synchronous reset loads 0x8A into the programming-interface byte (0x09), 0x0081 into the command word (0x04) and 0x0280 into the status word (0x06). It also loads revision 0x06 (0x08), class bytes 0x01/0x01 (0x0A/0x0B), capability pointer 0xC0 (0x34), interrupt line 0x0E (0x3C) and interrupt pin 0x01 (0x3D). During reset, `acc_rdata`, `acc_rvalid` and `irq_out` are zero.
- R2: Reset loads these 32-bit values: 0x0A090600 at 0x40, 0x00C00068 at 0x44, 0xA8A8A8A8 at 0x48, 0x000000FF at 0x4C, 0x07070707 at 0x50, 0x00000004 at 0x54, 0x00000200 at both 0x60 and 0x68, and 0x00020001 at 0xC0.
- R3: `acc_len` of 1, 2 or 4 accesses that many bytes starting at `acc_addr`, with byte k of the data word at offset `acc_addr`+k. Read data appears on `acc_rdata` with `acc_rvalid` high in the cycle after the request. Lanes beyond the length read as zero. Any other length is ignored completely: nothing is written and `acc_rvalid` stays low.
- R4: In the programming-interface byte, only bits 0 and 2 are writable.
- R5: Writes have no effect on vendor/device ID (0x00..0x03), revision, class bytes, interrupt line, status word, or the power-management block at 0xC0. The command word accepts writes to bits 0..10 only.
- R6: While the programming-interface low nibble is 0xA, every byte in 0x10..0x1F covered by a read returns zero. Other bytes of the same access return their stored values.
- R7: While the low nibble is not 0xA, the bytes in 0x10..0x1F read back as stored.
- R8: While the low nibble is 0xA, a 4-byte read at 0x20 whose stored word equals 0x00000001 returns 0x0000CC01. Any other length, stored value or mode returns the stored bytes.
- R9: The base-address registers at 0x10..0x23 reset to 0x00000001. Bits 1:0 of each register's lowest byte are read-only, and all other bits are writable.
- R10: One cycle after `irq_in[n]` changes, bit 7 of byte 0x70+8n equals the new level. Writes cannot change that bit. Bits 6:0 of those bytes are writable.
- R11: `irq_out[n]` equals `irq_in[n]` one cycle later.
- R12: Bytes 0x40..0x7F, apart from the interrupt status bits, are fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of lane 0 |
| acc_len | input | 3 | Access length in bytes (1, 2 or 4) |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rdata | output | 32 | Registered read data |
| acc_rvalid | output | 1 | Read data valid |
| irq_in | input | 2 | Channel interrupt levels |
| irq_out | output | 2 | Registered interrupt lines |

## Verification
The assertions assume the following about the inputs: they are synchronous to `clk`, a request lasts exactly one cycle, and at most one request is present per cycle. Every check that looks at the previous cycle ignores the first cycle after reset, so the inputs may hold any value while reset is high. The bench changes all inputs on the falling clock edge and holds each request for one cycle. It toggles the interrupt levels only between accesses, and it asserts reset mid-run while both interrupt levels are high.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int ADDR_W    = 8;
  localparam int CFG_BYTES = 1 << ADDR_W;
  localparam int LANES     = 4;
  localparam int DATA_W    = 8 * LANES;
  localparam int LEN_W     = 3;

  localparam logic [ADDR_W-1:0] PIF_OFS        = 8'h09;
  localparam logic [ADDR_W-1:0] CHAN_BAR_FIRST = 8'h10;
  localparam logic [ADDR_W-1:0] CHAN_BAR_LAST  = 8'h1F;
  localparam logic [ADDR_W-1:0] BAR_REGION_END = 8'h23;
  localparam logic [ADDR_W-1:0] DMA_BAR_OFS    = 8'h20;
  localparam logic [ADDR_W-1:0] VND_FIRST      = 8'h40;
  localparam logic [ADDR_W-1:0] VND_LAST       = 8'h7F;
  localparam logic [ADDR_W-1:0] IRQ_STAT_BASE  = 8'h70;
  localparam int                IRQ_STAT_STRIDE = 8;
  localparam int                IRQ_STAT_BIT    = 7;
  localparam logic [3:0]        COMPAT_NIBBLE   = 4'hA;
  localparam logic [DATA_W-1:0] IO_FLAG_ONLY    = 32'h0000_0001;
  localparam logic [DATA_W-1:0] DMA_BAR_FALLBACK = 32'h0000_CC01;

  typedef logic [CFG_BYTES-1:0][7:0] cfg_image_t;

  function automatic logic [31:0] reset_dword(input logic [ADDR_W-1:0] a,
                                              input logic [15:0] ven,
                                              input logic [15:0] dev);
    logic [ADDR_W-1:0] base;
    base = {a[ADDR_W-1:2], 2'b00};
    case (base)
      8'h00: return {dev, ven};
      8'h04: return 32'h0280_0081;
      8'h08: return 32'h0101_8A06;
      8'h10, 8'h14, 8'h18, 8'h1C, 8'h20: return IO_FLAG_ONLY;
      8'h34: return 32'h0000_00C0;
      8'h3C: return 32'h0000_010E;
      8'h40: return 32'h0A09_0600;
      8'h44: return 32'h00C0_0068;
      8'h48: return 32'hA8A8_A8A8;
      8'h4C: return 32'h0000_00FF;
      8'h50: return 32'h0707_0707;
      8'h54: return 32'h0000_0004;
      8'h60: return 32'h0000_0200;
      8'h68: return 32'h0000_0200;
      8'hC0: return 32'h0002_0001;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic is_irq_stat(input logic [ADDR_W-1:0] a, input int nch);
    int off;
    off = int'(a) - int'(IRQ_STAT_BASE);
    return (off >= 0) && (off % IRQ_STAT_STRIDE == 0) && (off / IRQ_STAT_STRIDE < nch);
  endfunction

  function automatic logic [7:0] wmask_byte(input logic [ADDR_W-1:0] a, input int nch);
    if (a == 8'h04) return 8'hFF;
    if (a == 8'h05) return 8'h07;
    if (a == PIF_OFS) return 8'h05;
    if (a >= CHAN_BAR_FIRST && a <= BAR_REGION_END)
      return (a[1:0] == 2'b00) ? 8'hFC : 8'hFF;
    if (a >= VND_FIRST && a <= VND_LAST)
      return is_irq_stat(a, nch) ? 8'h7F : 8'hFF;
    return 8'h00;
  endfunction

  function automatic cfg_image_t build_reset_image(input logic [15:0] ven,
                                                   input logic [15:0] dev);
    cfg_image_t img;
    logic [31:0] w;
    for (int i = 0; i < CFG_BYTES; i++) begin
      w = reset_dword(ADDR_W'(i), ven, dev);
      img[i] = w[8*(i%4) +: 8];
    end
    return img;
  endfunction

  function automatic cfg_image_t build_wmask_image(input int nch);
    cfg_image_t img;
    for (int i = 0; i < CFG_BYTES; i++) img[i] = wmask_byte(ADDR_W'(i), nch);
    return img;
  endfunction
endpackage

// File: rtl/ide_cfg_store.sv
module ide_cfg_store
  import ide_cfg_pkg::*;
#(
  parameter logic [15:0] VEN_ID = 16'h1AB7,
  parameter logic [15:0] DEV_ID = 16'h0C51,
  parameter int          NCH    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [LANES-1:0]              lane_en,
  input  logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [NCH-1:0]                irq_lvl,
  output logic [LANES-1:0][7:0]         lane_q,
  output logic [7:0]                    pif_q
);
  localparam cfg_image_t RST_IMG = build_reset_image(VEN_ID, DEV_ID);
  localparam cfg_image_t WM_IMG  = build_wmask_image(NCH);

  cfg_image_t cfg_q;
  cfg_image_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_en[i])
          cfg_d[lane_addr[i]] = (cfg_q[lane_addr[i]] & ~WM_IMG[lane_addr[i]])
                              | (wr_data[8*i +: 8] & WM_IMG[lane_addr[i]]);
      end
    end
    for (int n = 0; n < NCH; n++)
      cfg_d[IRQ_STAT_BASE + ADDR_W'(n * IRQ_STAT_STRIDE)][IRQ_STAT_BIT] = irq_lvl[n];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= RST_IMG;
    else     cfg_q <= cfg_d;
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) lane_q[i] = cfg_q[lane_addr[i]];
    pif_q = cfg_q[PIF_OFS];
  end

  // R4
  pif_ro_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(pif_q & 8'hFA));

  // R5
  id_ro_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable({cfg_q[3], cfg_q[2], cfg_q[1], cfg_q[0], cfg_q[8'h3C]}));

  for (genvar n = 0; n < NCH; n++) begin : g_irq_chk
    localparam logic [ADDR_W-1:0] STAT_A = IRQ_STAT_BASE + ADDR_W'(n * IRQ_STAT_STRIDE);
    // R10
    irq_mirror_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> cfg_q[STAT_A][IRQ_STAT_BIT] == $past(irq_lvl[n]));
  end
endmodule

// File: rtl/ide_cfg_rdpath.sv
module ide_cfg_rdpath
  import ide_cfg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [LANES-1:0]             lane_en,
  input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
  input  logic [LANES-1:0][7:0]        lane_q,
  input  logic [7:0]                   pif_q,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rvalid
);
  logic              compat;
  logic [LANES-1:0]  hide;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] word_fix;

  assign compat = (pif_q[3:0] == COMPAT_NIBBLE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hide[i] = compat && (lane_addr[i] >= CHAN_BAR_FIRST) && (lane_addr[i] <= CHAN_BAR_LAST);
    assign word[8*i +: 8] = (lane_en[i] && !hide[i]) ? lane_q[i] : 8'h00;
  end

  always_comb begin
    word_fix = word;
    if (compat && (lane_en == {LANES{1'b1}}) && (lane_addr[0] == DMA_BAR_OFS) && (word == IO_FLAG_ONLY))
      word_fix = DMA_BAR_FALLBACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= word_fix;
    end
  end

  // R6
  bar_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && compat && lane_en == 4'b0001 && lane_addr[0] >= CHAN_BAR_FIRST && lane_addr[0] <= CHAN_BAR_LAST)
    |=> (rdata == '0));

  // R3
  narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !lane_en[1]) |=> (rdata[DATA_W-1:8] == '0));
endmodule

// File: rtl/ide_cfg_irq.sv
module ide_cfg_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] irq_in,
  output logic [NCH-1:0] irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= irq_in;
  end

  // R11
  irq_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_out == $past(irq_in));
endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
  import ide_cfg_pkg::*;
#(
  parameter logic [15:0] VEN_ID = 16'h1AB7,
  parameter logic [15:0] DEV_ID = 16'h0C51,
  parameter int          NCH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_rvalid,
  input  logic [NCH-1:0]    irq_in,
  output logic [NCH-1:0]    irq_out
);
  logic                         len_ok;
  logic                         wr_en;
  logic                         rd_en;
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][ADDR_W-1:0] lane_addr;
  logic [LANES-1:0][7:0]        lane_q;
  logic [7:0]                   pif_q;

  assign len_ok = (acc_len != '0) && ((acc_len & (acc_len - 1'b1)) == '0)
                && (acc_len <= LEN_W'(LANES));
  assign wr_en  = acc_valid && acc_write && len_ok;
  assign rd_en  = acc_valid && !acc_write && len_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_addr[i] = acc_addr + ADDR_W'(i);
    assign lane_en[i]   = len_ok && (LEN_W'(i) < acc_len);
  end

  ide_cfg_store #(.VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .NCH(NCH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .lane_en(lane_en), .lane_addr(lane_addr),
    .wr_data(acc_wdata), .irq_lvl(irq_in), .lane_q(lane_q), .pif_q(pif_q)
  );

  ide_cfg_rdpath u_rdpath (
    .clk(clk), .rst(rst), .rd_en(rd_en), .lane_en(lane_en), .lane_addr(lane_addr),
    .lane_q(lane_q), .pif_q(pif_q), .rdata(acc_rdata), .rvalid(acc_rvalid)
  );

  ide_cfg_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out)
  );

  // R3
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc_rvalid == $past(acc_valid && !acc_write &&
                                       (acc_len == 3'd1 || acc_len == 3'd2 || acc_len == 3'd4)));
endmodule

// File: tb/ide_cfg_space_test.sv
module ide_cfg_space_test;
  localparam int CLK_NS   = 10;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [2:0]  len;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 3'd4, 32'h0C511AB7, 8'd1},   // R1 ids
    '{1'b0, 8'h04, 3'd4, 32'h02800081, 8'd1},   // R1 command/status
    '{1'b0, 8'h08, 3'd4, 32'h01018A06, 8'd1},   // R1 rev/class
    '{1'b0, 8'h3C, 3'd1, 32'h0000000E, 8'd1},   // R1 int line
    '{1'b0, 8'h34, 3'd1, 32'h000000C0, 8'd1},   // R1 cap ptr
    '{1'b0, 8'h40, 3'd4, 32'h0A090600, 8'd2},   // R2
    '{1'b0, 8'h44, 3'd4, 32'h00C00068, 8'd2},
    '{1'b0, 8'h48, 3'd4, 32'hA8A8A8A8, 8'd2},
    '{1'b0, 8'h4C, 3'd4, 32'h000000FF, 8'd2},
    '{1'b0, 8'h50, 3'd4, 32'h07070707, 8'd2},
    '{1'b0, 8'h54, 3'd4, 32'h00000004, 8'd2},
    '{1'b0, 8'h60, 3'd4, 32'h00000200, 8'd2},
    '{1'b0, 8'h68, 3'd4, 32'h00000200, 8'd2},
    '{1'b0, 8'hC0, 3'd4, 32'h00020001, 8'd2},
    '{1'b0, 8'h10, 3'd4, 32'h00000000, 8'd6},   // R6
    '{1'b0, 8'h1E, 3'd4, 32'h00010000, 8'd6},   // R6 straddle
    '{1'b0, 8'h20, 3'd4, 32'h0000CC01, 8'd8},   // R8 fallback
    '{1'b0, 8'h20, 3'd2, 32'h00000001, 8'd8},   // R8 short read
    '{1'b1, 8'h3C, 3'd1, 32'h00000055, 8'd5},
    '{1'b0, 8'h3C, 3'd4, 32'h0000010E, 8'd5},   // R5
    '{1'b1, 8'h00, 3'd4, 32'hFFFFFFFF, 8'd5},
    '{1'b0, 8'h00, 3'd4, 32'h0C511AB7, 8'd5},   // R5
    '{1'b1, 8'h09, 3'd1, 32'h000000FF, 8'd4},
    '{1'b0, 8'h08, 3'd4, 32'h01018F06, 8'd4},   // R4
    '{1'b0, 8'h10, 3'd4, 32'h00000001, 8'd7},   // R7
    '{1'b0, 8'h20, 3'd4, 32'h00000001, 8'd8},   // R8 native
    '{1'b1, 8'h10, 3'd4, 32'h12345678, 8'd9},
    '{1'b0, 8'h10, 3'd4, 32'h12345679, 8'd9},   // R9
    '{1'b1, 8'h09, 3'd1, 32'h00000000, 8'd4},
    '{1'b0, 8'h08, 3'd4, 32'h01018A06, 8'd4},   // R4
    '{1'b0, 8'h10, 3'd4, 32'h00000000, 8'd6},   // R6
    '{1'b1, 8'h20, 3'd4, 32'h0000D000, 8'd8},
    '{1'b0, 8'h20, 3'd4, 32'h0000D001, 8'd8},   // R8 programmed
    '{1'b1, 8'h48, 3'd2, 32'h00001234, 8'd12},
    '{1'b0, 8'h48, 3'd4, 32'hA8A81234, 8'd12},  // R12
    '{1'b0, 8'h49, 3'd1, 32'h00000012, 8'd3},   // R3
    '{1'b1, 8'h48, 3'd3, 32'hFFFFFFFF, 8'd3},
    '{1'b0, 8'h48, 3'd4, 32'hA8A81234, 8'd3},   // R3 bad length ignored
    '{1'b1, 8'h04, 3'd4, 32'hFFFFFFFF, 8'd5},
    '{1'b0, 8'h04, 3'd4, 32'h028007FF, 8'd5},   // R5
    '{1'b1, 8'h70, 3'd1, 32'h000000FF, 8'd10},
    '{1'b0, 8'h70, 3'd1, 32'h0000007F, 8'd10},  // R10
    '{1'b1, 8'hC0, 3'd4, 32'h00000000, 8'd5},
    '{1'b0, 8'hC0, 3'd4, 32'h00020001, 8'd5},   // R5
    '{1'b0, 8'h4E, 3'd4, 32'h07070000, 8'd3}    // R3 little-endian straddle
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [2:0]  acc_len = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_rvalid;
  logic [1:0]  irq_in = '0;
  logic [1:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  ide_cfg_space uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_len = l; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [7:0] a, input logic [2:0] l, input logic [31:0] exp);
    access(1'b0, a, l, 32'h0);
    check(tag, acc_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {31'h0, acc_rvalid}, 32'h0);
    check("R1 rdata in reset", acc_rdata, 32'h0);
    check("R1 irq_out in reset", {30'h0, irq_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      access(VEC[k].wr, VEC[k].addr, VEC[k].len, VEC[k].data);
      if (!VEC[k].wr)
        check($sformatf("R%0d vector %0d", VEC[k].req, k), acc_rdata, VEC[k].data);
    end

    // R3: valid flag for good and bad lengths
    access(1'b0, 8'h48, 3'd2, 32'h0);
    check("R3 rvalid after read", {31'h0, acc_rvalid}, 32'h1);
    access(1'b0, 8'h48, 3'd3, 32'h0);
    check("R3 rvalid on bad length", {31'h0, acc_rvalid}, 32'h0);

    // R10 / R11: channel 0 high
    irq_in = 2'b01;
    @(negedge clk);
    check("R11 irq_out ch0", {30'h0, irq_out}, 32'h1);
    read_check("R10 stat ch0 set", 8'h70, 3'd1, 32'h000000FF);
    read_check("R10 stat ch1 clear", 8'h78, 3'd1, 32'h00000000);
    irq_in = 2'b10;
    @(negedge clk);
    check("R11 irq_out ch1", {30'h0, irq_out}, 32'h2);
    read_check("R10 stat ch0 clear", 8'h70, 3'd1, 32'h0000007F);
    read_check("R10 stat ch1 set", 8'h78, 3'd1, 32'h00000080);
    access(1'b1, 8'h78, 3'd1, 32'h00000000);
    read_check("R10 write cannot clear", 8'h78, 3'd1, 32'h00000080);

    // R1: mid-run reset with interrupts high
    irq_in = 2'b11;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 irq_out held in reset", {30'h0, irq_out}, 32'h0);
    check("R1 rvalid held in reset", {31'h0, acc_rvalid}, 32'h0);
    rst = 1'b0;
    irq_in = 2'b00;
    @(negedge clk);
    read_check("R1 prog-if after reset", 8'h09, 3'd1, 32'h0000008A);
    read_check("R2 timing after reset", 8'h48, 3'd4, 32'hA8A8A8A8);
    read_check("R6 bar hidden after reset", 8'h1C, 3'd4, 32'h00000000);
    read_check("R8 fallback after reset", 8'h20, 3'd4, 32'h0000CC01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule